// File: doc/BRIEF.md
# Multi-Channel Interrupt Aggregation and Global Control Registers

This block is the shared register bank of a four-channel serial controller. A host reaches it through a byte-wide read/write port addressed by an 8-bit address. It gathers the already-qualified interrupt state of each channel: a pending flag, a 3-bit source code and a sleep indication. It also collects the expiry event of a shared timer. From these it presents a summary view, a packed view of all source codes and a single interrupt request line.

The block also holds the global controls that fan out to the channels. These are per-channel reset pulses, per-channel sleep enables, per-channel 8x-oversampling selects and a broadcast-write flag. A wake-up event is latched only when all four channels were asleep and at least one of them then wakes. Reading the summary register acknowledges that event. Reading the timer status register acknowledges the timer event.

Top module: `chan_irq_regs`

## Requirements
- R1: A read of 0x80 returns the channel pending flags in bits 3:0 (bit N is channel N) and zero in bits 7:4; the value follows the flags with no latching.
- R2: The four 3-bit source codes form one 12-bit field with channel 0 lowest. 0x81 returns field bits 7:0: channel 0 in 2:0, channel 1 in 5:3, channel 2 bits 1:0 in 7:6. 0x82 returns field bits 11:8 in its bits 3:0: channel 2 bit 2 in bit 0, channel 3 in bits 3:1. Bits 7:4 of 0x82 read zero.
- R3: 0x83, the write-only address 0x8A and every address without a register read 0x00.
- R4: A write to 0x8A drives `ch_reset` with write-data bits 3:0 for exactly the one cycle after the write, then returns to zero; nothing is stored.
- R5: 0x8B is read/write; bits 3:0 drive `sleep_en` and read back, bits 7:4 read zero.
- R6: A wake-up event is latched when all four `ch_asleep` bits were 1 in the previous cycle and not all are 1 now. A partial sleep followed by a wake latches nothing. A read of 0x80 clears the event.
- R7: Bit 0 of 0x84 enables the timer interrupt. With it set, a `tmr_expire` pulse latches a timer event, seen at bit 0 of 0x85 one cycle later. A read of 0x85 clears it. With the enable clear, the pulse is ignored.
- R8: 0x88 bits 3:0 drive `ovs8_sel` and read back; 0x8E bit 0 drives `bcast_wr` and reads back.
- R9: 0x8C returns the revision constant 0x01 and 0x8D returns the device identifier 0xA4.
- R10: `irq_out` is the OR of the four pending flags, the latched timer event and the latched wake-up event.
- R11: After reset every control output is zero, and every register reads zero apart from the constants and the live flag views.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, triggers read side effects at the clock edge |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| ch_pend | input | 4 | Qualified interrupt pending flag per channel |
| ch_code | input | 12 | Source codes, channel N in bits 3N+2:3N |
| ch_asleep | input | 4 | Channel in sleep state |
| tmr_expire | input | 1 | Timer expiry pulse |
| irq_out | output | 1 | Summary interrupt request |
| ch_reset | output | 4 | One-cycle channel reset pulses |
| sleep_en | output | 4 | Per-channel sleep enable |
| ovs8_sel | output | 4 | Per-channel 8x-sampling select |
| bcast_wr | output | 1 | Broadcast writes to all channels |

## Verification
The assertions assume that `reg_wr` and `reg_rd` are never high together and that `tmr_expire` is a single-cycle pulse. They also assume that `ch_pend`, `ch_code` and `ch_asleep` change only away from the clock edge. The bench drives every input at the falling edge, issues each access as a one-cycle strobe, and pulses the timer for exactly one cycle. The wake-up checks step `ch_asleep` through all-asleep and partially-asleep patterns, one cycle at a time, so the previous-cycle condition is exercised exactly.

// File: rtl/chan_irq_pkg.sv
package chan_irq_pkg;
    localparam int NCH        = 4;
    localparam int CODE_W     = 3;
    localparam int FIELD_W    = NCH * CODE_W;
    localparam int PACK_BYTES = (FIELD_W + 7) / 8;

    localparam logic [7:0] A_SUMMARY  = 8'h80;
    localparam logic [7:0] A_SRC_BASE = 8'h81;
    localparam logic [7:0] A_RSVD     = 8'h83;
    localparam logic [7:0] A_TMR_CTL  = 8'h84;
    localparam logic [7:0] A_TMR_STS  = 8'h85;
    localparam logic [7:0] A_OVS8     = 8'h88;
    localparam logic [7:0] A_CHRST    = 8'h8A;
    localparam logic [7:0] A_SLEEP    = 8'h8B;
    localparam logic [7:0] A_REV      = 8'h8C;
    localparam logic [7:0] A_DEVID    = 8'h8D;
    localparam logic [7:0] A_BCAST    = 8'h8E;

    typedef struct packed {
        logic           tmr_en;
        logic           tmr_evt;
        logic [NCH-1:0] ovs8;
        logic [NCH-1:0] sleep;
        logic           bcast;
        logic [NCH-1:0] rst_pulse;
    } regs_t;

    typedef struct packed {
        logic all_asleep;
        logic wake;
    } wake_t;
endpackage

// File: rtl/irq_code_pack.sv
module irq_code_pack
    import chan_irq_pkg::*;
(
    input  logic [FIELD_W-1:0]      codes_i,
    output logic [PACK_BYTES*8-1:0] packed_o
);
    localparam int PAD = PACK_BYTES * 8 - FIELD_W;

    for (genvar n = 0; n < NCH; n++) begin : g_chan
        assign packed_o[n*CODE_W +: CODE_W] = codes_i[n*CODE_W +: CODE_W];
    end

    if (PAD > 0) begin : g_pad
        assign packed_o[PACK_BYTES*8-1 -: PAD] = '0;
    end
endmodule

// File: rtl/wake_detect.sv
module wake_detect
    import chan_irq_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] asleep_i,
    input  logic           clr_i,
    output logic           wake_o
);
    wake_t w_d, w_q;

    always_comb begin
        w_d            = w_q;
        w_d.all_asleep = &asleep_i;
        if (clr_i)
            w_d.wake = 1'b0;
        if (w_q.all_asleep && !(&asleep_i))
            w_d.wake = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign wake_o = w_q.wake;

    assert_wake_needs_all_asleep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(w_q.wake) |-> ($past(&asleep_i, 2) && !$past(&asleep_i)));

    assert_wake_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (w_q.wake && clr_i && !(w_q.all_asleep && !(&asleep_i))) |=> !w_q.wake);
endmodule

// File: rtl/chan_irq_regs.sv
module chan_irq_regs
    import chan_irq_pkg::*;
#(
    parameter logic [7:0] DEV_ID  = 8'hA4,
    parameter logic [7:0] DEV_REV = 8'h01
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [7:0]           reg_addr,
    input  logic [7:0]           reg_wdata,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    output logic [7:0]           reg_rdata,
    input  logic [NCH-1:0]       ch_pend,
    input  logic [FIELD_W-1:0]   ch_code,
    input  logic [NCH-1:0]       ch_asleep,
    input  logic                 tmr_expire,
    output logic                 irq_out,
    output logic [NCH-1:0]       ch_reset,
    output logic [NCH-1:0]       sleep_en,
    output logic [NCH-1:0]       ovs8_sel,
    output logic                 bcast_wr
);
    localparam int HI = 8 - NCH;

    regs_t st_d, st_q;
    logic [PACK_BYTES*8-1:0] src_packed;
    logic                    wake_evt;
    logic                    wake_clr;
    logic [7:0]              unused_wdata;

    assign unused_wdata = reg_wdata;

    irq_code_pack u_pack (
        .codes_i  (ch_code),
        .packed_o (src_packed)
    );

    assign wake_clr = reg_rd && (reg_addr == A_SUMMARY);

    wake_detect u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .asleep_i (ch_asleep),
        .clr_i    (wake_clr),
        .wake_o   (wake_evt)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rst_pulse = '0;
        if (reg_wr) begin
            case (reg_addr)
                A_TMR_CTL: st_d.tmr_en    = reg_wdata[0];
                A_OVS8:    st_d.ovs8      = reg_wdata[NCH-1:0];
                A_CHRST:   st_d.rst_pulse = reg_wdata[NCH-1:0];
                A_SLEEP:   st_d.sleep     = reg_wdata[NCH-1:0];
                A_BCAST:   st_d.bcast     = reg_wdata[0];
                default: ;
            endcase
        end
        if (reg_rd && reg_addr == A_TMR_STS)
            st_d.tmr_evt = 1'b0;
        if (tmr_expire && st_q.tmr_en)
            st_d.tmr_evt = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_SUMMARY: reg_rdata = {{HI{1'b0}}, ch_pend};
            A_TMR_CTL: reg_rdata = {7'd0, st_q.tmr_en};
            A_TMR_STS: reg_rdata = {7'd0, st_q.tmr_evt};
            A_OVS8:    reg_rdata = {{HI{1'b0}}, st_q.ovs8};
            A_SLEEP:   reg_rdata = {{HI{1'b0}}, st_q.sleep};
            A_REV:     reg_rdata = DEV_REV;
            A_DEVID:   reg_rdata = DEV_ID;
            A_BCAST:   reg_rdata = {7'd0, st_q.bcast};
            default:   reg_rdata = '0;
        endcase
        for (int k = 0; k < PACK_BYTES; k++) begin
            if (reg_addr == A_SRC_BASE + 8'(k) && reg_addr != A_RSVD)
                reg_rdata = src_packed[k*8 +: 8];
        end
    end

    assign irq_out  = (|ch_pend) | st_q.tmr_evt | wake_evt;
    assign ch_reset = st_q.rst_pulse;
    assign sleep_en = st_q.sleep;
    assign ovs8_sel = st_q.ovs8;
    assign bcast_wr = st_q.bcast;

    assert_summary_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_SUMMARY) |-> (reg_rdata[7:NCH] == '0));

    assert_reserved_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_RSVD || reg_addr == A_CHRST) |-> (reg_rdata == 8'h00));

    assert_reset_pulse_origin_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_reset != '0) |-> $past(reg_wr && reg_addr == A_CHRST));

    assert_timer_event_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.tmr_evt) |-> $past(tmr_expire && st_q.tmr_en));

    assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_out |-> (ch_pend == '0));
endmodule

// File: tb/chan_irq_regs_bench.sv
module chan_irq_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_rdata;
    logic [3:0]  ch_pend = '0;
    logic [11:0] ch_code = '0;
    logic [3:0]  ch_asleep = '0;
    logic        tmr_expire = 1'b0;
    logic        irq_out;
    logic [3:0]  ch_reset, sleep_en, ovs8_sel;
    logic        bcast_wr;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    chan_irq_regs u_chan_irq_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .ch_pend(ch_pend), .ch_code(ch_code), .ch_asleep(ch_asleep),
        .tmr_expire(tmr_expire), .irq_out(irq_out), .ch_reset(ch_reset),
        .sleep_en(sleep_en), .ovs8_sel(ovs8_sel), .bcast_wr(bcast_wr)
    );

    // {pend, code3, code2, code1, code0}
    localparam logic [15:0] VEC [8] = '{
        16'h0_000, 16'h1_007, 16'h2_038, 16'h4_1C0, 16'h8_E00,
        16'hF_FFF, 16'hA_5A5, 16'h5_924
    };

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #2 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    function automatic logic [7:0] ref_lo(logic [2:0] c0, c1, c2);
        return {c2[1:0], c1, c0};
    endfunction
    function automatic logic [7:0] ref_hi(logic [2:0] c2, c3);
        return {4'b0000, c3, c2[2]};
    endfunction

    task automatic check_view(logic [3:0] p, logic [11:0] c);
        logic [7:0] v;
        @(negedge clk);
        ch_pend = p; ch_code = c;
        rd(8'h80, v); chk("R1", v, {4'b0, p});
        rd(8'h81, v); chk("R2", v, ref_lo(c[2:0], c[5:3], c[8:6]));
        rd(8'h82, v); chk("R2", v, ref_hi(c[8:6], c[11:9]));
        #1 chk("R10", {7'd0, irq_out}, {7'd0, |p});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11", {ch_reset, sleep_en}, 8'h00);
        chk("R11", {3'd0, bcast_wr, ovs8_sel}, 8'h00);
        chk("R11", {7'd0, irq_out}, 8'h00);
        rd(8'h85, v); chk("R11", v, 8'h00);
        rd(8'h8B, v); chk("R11", v, 8'h00);

        for (int i = 0; i < 8; i++)
            check_view(VEC[i][15:12], VEC[i][11:0]);
        for (int i = 0; i < 20; i++)
            check_view(4'($urandom), 12'($urandom));
        @(negedge clk); ch_pend = '0; ch_code = 12'hFFF;

        // R3 reserved and unmapped
        rd(8'h83, v); chk("R3", v, 8'h00);
        rd(8'h8A, v); chk("R3", v, 8'h00);
        rd(8'h00, v); chk("R3", v, 8'h00);
        rd(8'h9F, v); chk("R3", v, 8'h00);

        // R4 reset pulse
        wr(8'h8A, 8'hF5);
        chk("R4", {4'd0, ch_reset}, 8'h05);
        @(negedge clk); chk("R4", {4'd0, ch_reset}, 8'h00);

        // R5 sleep, R8 controls, R9 constants
        wr(8'h8B, 8'hFA); chk("R5", {4'd0, sleep_en}, 8'h0A);
        rd(8'h8B, v); chk("R5", v, 8'h0A);
        wr(8'h88, 8'hF6); chk("R8", {4'd0, ovs8_sel}, 8'h06);
        rd(8'h88, v); chk("R8", v, 8'h06);
        wr(8'h8E, 8'hFF); chk("R8", {7'd0, bcast_wr}, 8'h01);
        rd(8'h8E, v); chk("R8", v, 8'h01);
        rd(8'h8C, v); chk("R9", v, 8'h01);
        rd(8'h8D, v); chk("R9", v, 8'hA4);

        // R7 timer disabled: pulse ignored
        @(negedge clk); tmr_expire = 1'b1;
        @(negedge clk); tmr_expire = 1'b0;
        chk("R7", {7'd0, irq_out}, 8'h00);
        rd(8'h85, v); chk("R7", v, 8'h00);
        // R7 timer enabled
        wr(8'h84, 8'h01);
        @(negedge clk); tmr_expire = 1'b1;
        @(negedge clk); tmr_expire = 1'b0;
        chk("R10", {7'd0, irq_out}, 8'h01);
        rd(8'h85, v); chk("R7", v, 8'h01);
        rd(8'h85, v); chk("R7", v, 8'h00);
        chk("R7", {7'd0, irq_out}, 8'h00);

        // R6 partial sleep then wake: nothing latched
        @(negedge clk); ch_asleep = 4'h7;
        @(negedge clk); ch_asleep = 4'h3;
        @(negedge clk); chk("R6", {7'd0, irq_out}, 8'h00);
        // R6 all asleep then one wakes
        ch_asleep = 4'hF;
        @(negedge clk); chk("R6", {7'd0, irq_out}, 8'h00);
        ch_asleep = 4'hE;
        @(negedge clk); chk("R6", {7'd0, irq_out}, 8'h01);
        rd(8'h80, v); chk("R6", v, 8'h00);
        @(negedge clk); chk("R6", {7'd0, irq_out}, 8'h00);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule